// File: doc/BRIEF.md
# Floppy Head Seek and Homing Controller

This block positions a floppy drive head on a requested cylinder. It drives a direction line and an active-low step line, and it watches a track-zero sense input. All timing comes from counters on the reference clock: the width of the step pulse, the gap between steps and the settling time after the last step. The clock rate and each delay are parameters.

A seek command carries a target track. The controller homes the head first if it has not been homed since reset or since a recalibrate, or if the target is track 0. Homing steps toward track zero until the sense input reports track zero. It gives up after a bounded number of steps, and the outcome is reported on a drive-present output. The controller then steps one track at a time toward the target. Whenever the sense input reports track zero during the seek, its internal track count is forced back to zero.

After the last step it waits out a settling delay. It then updates a low-track output, which is high for targets below a threshold (43 by default), and gives a one-cycle done pulse. A recalibrate command forgets the homed state and seeks to track 0. Commands that arrive while the controller is busy are dropped.

Top module: `head_seek_ctrl`

## Requirements
- R1: After reset the outputs are: step_n 1, dir_out 0, busy 0, done 0, low_track 1 and drive_present 0.
- R2: Each step has three phases. step_n is held high for the pulse time, then low for exactly the pulse time, then high again, followed by at least the step gap before the next step begins. Successive falling edges of step_n are therefore at least two pulse times plus one gap apart.
- R3: dir_out is 0 for steps toward track zero and 1 for steps away from it. It does not change while step_n is low.
- R4: Homing checks track-zero sense before each step and issues at most HOME_LIMIT steps toward zero. If track zero is seen, drive_present becomes 1. After HOME_LIMIT steps without seeing it, drive_present becomes 0 and no further check is made. In both cases the track count becomes 0 and the head counts as homed.
- R5: A seek homes first only when the head is not homed or the target is 0. Otherwise it steps directly from the current track.
- R6: A seek issues exactly |target − current| steps, all in the direction that reduces the distance.
- R7: During a seek, when the current track differs from the target and track-zero sense is active, the current track is taken as 0 before the next step is chosen.
- R8: done is a one-cycle pulse. It is raised no earlier than the step gap plus the settling time after step_n returns high at the end of the last step, and busy is low in the same cycle.
- R9: low_track changes only in the cycle done is raised. It becomes 1 for targets below LOW_TRACK_LIMIT (43) and 0 otherwise.
- R10: A recalibrate clears the homed state and then seeks to track 0. When recalibrate and seek arrive in the same cycle, recalibrate is taken.
- R11: seek_req and recal_req are ignored while busy is high. The seek in progress completes with its original target and no further command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seek_req | input | 1 | One-cycle request to seek to seek_track |
| seek_track | input | TRACK_W | Target track for seek_req |
| recal_req | input | 1 | One-cycle request to recalibrate (home, then track 0) |
| trk0_sense | input | 1 | Track-zero sense from the drive (polarity set by TRK0_ACTIVE_LOW) |
| dir_out | output | 1 | Step direction: 0 toward track zero, 1 away |
| step_n | output | 1 | Active-low step pulse |
| low_track | output | 1 | High when the settled target is below LOW_TRACK_LIMIT |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| drive_present | output | 1 | Result of the last homing: track zero was found |

## Verification
The bench runs a small timing configuration with a head model that moves one track on each rising edge of step_n. It sweeps targets up and down across the low-track threshold. A design with an off-by-one compare would flip low_track at 42 or 44. The bench also covers homing from a head beyond the step limit and with no drive connected. A design that checked once more or stepped once more would report the wrong presence or leave the head at the wrong position. A deliberate head slip tests track-zero resynchronisation: without it the seek ends far short of its target. A second command issued while busy must not redirect the seek, and must not start a new one after done.

// File: rtl/head_seek_pkg.sv
package head_seek_pkg;

   typedef enum logic [2:0] {
      SK_IDLE,
      SK_HOME_CHECK,
      SK_HOME_WAIT,
      SK_SEEK_CHECK,
      SK_SEEK_WAIT,
      SK_SETTLE
   } seek_state_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LEAD,
      PH_LOW,
      PH_GAP
   } step_phase_t;

   // Cycles of a delay given in microseconds, rounded up, never below one.
   function automatic int us_to_cycles(input int clk_khz, input int us);
      longint c;
      c = (longint'(clk_khz) * longint'(us) + 64'sd999) / 64'sd1000;
      if (c < 1) c = 1;
      return int'(c);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hs_countdown.sv
module hs_countdown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] value,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= value;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   // High in the final cycle of a loaded interval.
   assign last = (cnt == W'(1));

endmodule

// File: rtl/hs_step_gen.sv
module hs_step_gen
   import head_seek_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int PULSE_CYC = 4,
   parameter int GAP_CYC   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic step_n,
   output logic step_done
);

   step_phase_t      phase;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             last;

   always_comb begin
      ld     = 1'b0;
      ld_val = CNT_W'(PULSE_CYC);
      unique case (phase)
         PH_IDLE: ld = start;
         PH_LEAD: ld = last;
         PH_LOW: begin
            ld     = last;
            ld_val = CNT_W'(GAP_CYC);
         end
         default: ld = 1'b0;
      endcase
   end

   hs_countdown #(.W(CNT_W)) u_phase_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld),
      .value (ld_val),
      .last  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         step_done <= 1'b0;
      end else begin
         step_done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) phase <= PH_LEAD;
            PH_LEAD: if (last)  phase <= PH_LOW;
            PH_LOW:  if (last)  phase <= PH_GAP;
            PH_GAP: if (last) begin
               phase     <= PH_IDLE;
               step_done <= 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign step_n = (phase != PH_LOW);

   // R2: the sequencer never receives a new step while one is running
   a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (phase == PH_IDLE));

   // R2: a finished step always ends with the line high
   a_r2_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> step_n);

endmodule

// File: rtl/hs_seek_fsm.sv
module hs_seek_fsm
   import head_seek_pkg::*;
#(
   parameter int TRACK_W         = 8,
   parameter int HOME_LIMIT      = 100,
   parameter int LOW_TRACK_LIMIT = 43
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seek_req,
   input  logic [TRACK_W-1:0] seek_track,
   input  logic               recal_req,
   input  logic               trk0,
   input  logic               step_done,
   input  logic               settle_last,
   output logic               step_start,
   output logic               dir,
   output logic               settle_load,
   output logic               busy,
   output logic               done,
   output logic               low_track,
   output logic               drive_present
);

   localparam int HOME_W = $clog2(HOME_LIMIT + 1);

   seek_state_t        state;
   logic [TRACK_W-1:0] tgt;
   logic [TRACK_W-1:0] cur;
   logic [TRACK_W-1:0] eff_cur;
   logic [HOME_W-1:0]  home_cnt;
   logic               homed;

   // Track-zero sense overrides the count before each step decision.
   assign eff_cur = trk0 ? '0 : cur;
   assign busy    = (state != SK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= SK_IDLE;
         tgt           <= '0;
         cur           <= '0;
         home_cnt      <= '0;
         homed         <= 1'b0;
         dir           <= 1'b0;
         step_start    <= 1'b0;
         settle_load   <= 1'b0;
         done          <= 1'b0;
         low_track     <= 1'b1;
         drive_present <= 1'b0;
      end else begin
         step_start  <= 1'b0;
         settle_load <= 1'b0;
         done        <= 1'b0;
         unique case (state)
            SK_IDLE: begin
               if (recal_req) begin
                  tgt      <= '0;
                  homed    <= 1'b0;
                  home_cnt <= '0;
                  state    <= SK_HOME_CHECK;
               end else if (seek_req) begin
                  tgt <= seek_track;
                  if (!homed || (seek_track == '0)) begin
                     home_cnt <= '0;
                     state    <= SK_HOME_CHECK;
                  end else begin
                     state <= SK_SEEK_CHECK;
                  end
               end
            end
            SK_HOME_CHECK: begin
               if (home_cnt == HOME_W'(HOME_LIMIT)) begin
                  drive_present <= 1'b0;
                  homed         <= 1'b1;
                  cur           <= '0;
                  state         <= SK_SEEK_CHECK;
               end else if (trk0) begin
                  drive_present <= 1'b1;
                  homed         <= 1'b1;
                  cur           <= '0;
                  state         <= SK_SEEK_CHECK;
               end else begin
                  dir        <= 1'b0;
                  step_start <= 1'b1;
                  home_cnt   <= home_cnt + 1'b1;
                  state      <= SK_HOME_WAIT;
               end
            end
            SK_HOME_WAIT: if (step_done) state <= SK_HOME_CHECK;
            SK_SEEK_CHECK: begin
               if (tgt == cur) begin
                  settle_load <= 1'b1;
                  state       <= SK_SETTLE;
               end else if (tgt > eff_cur) begin
                  dir        <= 1'b1;
                  cur        <= eff_cur + 1'b1;
                  step_start <= 1'b1;
                  state      <= SK_SEEK_WAIT;
               end else if (tgt < eff_cur) begin
                  dir        <= 1'b0;
                  cur        <= eff_cur - 1'b1;
                  step_start <= 1'b1;
                  state      <= SK_SEEK_WAIT;
               end else begin
                  cur <= eff_cur;
               end
            end
            SK_SEEK_WAIT: if (step_done) state <= SK_SEEK_CHECK;
            SK_SETTLE: begin
               if (settle_last) begin
                  low_track <= (int'(tgt) < LOW_TRACK_LIMIT);
                  done      <= 1'b1;
                  state     <= SK_IDLE;
               end
            end
            default: state <= SK_IDLE;
         endcase
      end
   end

   // R4: homing never exceeds its step budget
   a_r4_home_bound: assert property (@(posedge clk) disable iff (!rst_n)
      home_cnt <= HOME_W'(HOME_LIMIT));

   // R8: completion lasts one cycle and coincides with idle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: the low-track line moves only with completion
   a_r9_lowtrk_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      (low_track != $past(low_track)) |-> done);

   // R11: requests during a command leave the target alone
   a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (seek_req || recal_req)) |=> (tgt == $past(tgt)));

endmodule

// File: rtl/head_seek_ctrl.sv
module head_seek_ctrl
   import head_seek_pkg::*;
#(
   parameter int CLK_KHZ         = 125000,
   parameter int STEP_PULSE_US   = 6,
   parameter int STEP_GAP_US     = 6000,
   parameter int SETTLE_US       = 50000,
   parameter int HOME_LIMIT      = 100,
   parameter int TRACK_W         = 8,
   parameter int LOW_TRACK_LIMIT = 43,
   parameter int SYNC_STAGES     = 2,
   parameter bit TRK0_ACTIVE_LOW = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seek_req,
   input  logic [TRACK_W-1:0] seek_track,
   input  logic               recal_req,
   input  logic               trk0_sense,
   output logic               dir_out,
   output logic               step_n,
   output logic               low_track,
   output logic               busy,
   output logic               done,
   output logic               drive_present
);

   localparam int PULSE_CYC  = us_to_cycles(CLK_KHZ, STEP_PULSE_US);
   localparam int GAP_CYC    = us_to_cycles(CLK_KHZ, STEP_GAP_US);
   localparam int SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
   localparam int CNT_W      = $clog2(max3(PULSE_CYC, GAP_CYC, SETTLE_CYC) + 1);

   if (CLK_KHZ < 1 || STEP_PULSE_US < 1 || STEP_GAP_US < 1 || SETTLE_US < 1) begin : g_bad_timing
      $error("head_seek_ctrl: clock and delays must be positive");
   end
   if (HOME_LIMIT < 1) begin : g_bad_home
      $error("head_seek_ctrl: HOME_LIMIT must be at least 1");
   end
   if (TRACK_W < 1 || LOW_TRACK_LIMIT < 1 || LOW_TRACK_LIMIT >= (1 << TRACK_W)) begin : g_bad_track
      $error("head_seek_ctrl: LOW_TRACK_LIMIT must fit in TRACK_W");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("head_seek_ctrl: SYNC_STAGES must be 0..4");
   end

   // Track-zero sense: polarity, then optional synchroniser.
   logic trk0_pol;
   logic trk0_s;

   assign trk0_pol = trk0_sense ^ TRK0_ACTIVE_LOW;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign trk0_s = trk0_pol;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= trk0_pol;
            for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign trk0_s = sr[SYNC_STAGES-1];
   end

   logic step_start;
   logic step_done;
   logic settle_load;
   logic settle_last;

   hs_seek_fsm #(
      .TRACK_W         (TRACK_W),
      .HOME_LIMIT      (HOME_LIMIT),
      .LOW_TRACK_LIMIT (LOW_TRACK_LIMIT)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .seek_req      (seek_req),
      .seek_track    (seek_track),
      .recal_req     (recal_req),
      .trk0          (trk0_s),
      .step_done     (step_done),
      .settle_last   (settle_last),
      .step_start    (step_start),
      .dir           (dir_out),
      .settle_load   (settle_load),
      .busy          (busy),
      .done          (done),
      .low_track     (low_track),
      .drive_present (drive_present)
   );

   hs_step_gen #(
      .CNT_W     (CNT_W),
      .PULSE_CYC (PULSE_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (step_start),
      .step_n    (step_n),
      .step_done (step_done)
   );

   hs_countdown #(.W(CNT_W)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (settle_load),
      .value (CNT_W'(SETTLE_CYC)),
      .last  (settle_last)
   );

   // R2: a step pulse only appears inside a command
   a_r2_step_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !step_n |-> busy);

   // R3: direction holds while the step line is low
   a_r3_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !step_n |-> $stable(dir_out));

endmodule

// File: tb/head_seek_ctrl_test.sv
module head_seek_ctrl_test;

   localparam int CLK_KHZ  = 1000;
   localparam int PULSE    = 2;
   localparam int GAP      = 10;
   localparam int SETTLE   = 30;
   localparam int HLIM     = 12;
   localparam int TW       = 7;
   localparam int LOWLIM   = 43;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seek_req = 1'b0;
   logic [TW-1:0] seek_track = '0;
   logic          recal_req = 1'b0;
   logic          trk0_sense;
   logic          dir_out, step_n, low_track, busy, done, drive_present;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   int  pos    = 0;
   bit  connected = 1'b1;
   int  n_in   = 0;
   int  n_out  = 0;
   bit  done_seen = 1'b0;
   bit  have_fall = 1'b0;
   int  last_fall = 0;
   int  last_rise = 0;
   int  low_run  = 0;
   bit  fall_dir = 1'b0;
   bit  prev_step_n = 1'b1;
   bit  prev_done = 1'b0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   assign trk0_sense = connected && (pos == 0);

   head_seek_ctrl #(
      .CLK_KHZ         (CLK_KHZ),
      .STEP_PULSE_US   (PULSE),
      .STEP_GAP_US     (GAP),
      .SETTLE_US       (SETTLE),
      .HOME_LIMIT      (HLIM),
      .TRACK_W         (TW),
      .LOW_TRACK_LIMIT (LOWLIM),
      .SYNC_STAGES     (2),
      .TRK0_ACTIVE_LOW (1'b0)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .seek_req      (seek_req),
      .seek_track    (seek_track),
      .recal_req     (recal_req),
      .trk0_sense    (trk0_sense),
      .dir_out       (dir_out),
      .step_n        (step_n),
      .low_track     (low_track),
      .busy          (busy),
      .done          (done),
      .drive_present (drive_present)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   // Head model and line monitor, sampled away from the active edge.
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_step_n && !step_n) begin
            if (have_fall) chk_ge("R2 step spacing", cyc - last_fall, 2*PULSE + GAP, 100000);
            have_fall = 1'b1;
            last_fall = cyc;
            fall_dir  = dir_out;
            low_run   = 0;
            if (dir_out) n_out++; else n_in++;
         end
         if (!step_n) begin
            low_run++;
            if (dir_out != fall_dir) chk("R3 dir stable while low", int'(dir_out), int'(fall_dir));
         end
         if (!prev_step_n && step_n) begin
            chk("R2 low width", low_run, PULSE);
            last_rise = cyc;
            if (fall_dir) pos++;
            else if (pos > 0) pos--;
         end
         if (done) begin
            if (prev_done) chk("R8 done single cycle", 1, 0);
            chk("R8 busy low with done", int'(busy), 0);
            if (have_fall) chk_ge("R8 settle delay", cyc - last_rise, GAP + SETTLE, GAP + SETTLE + 6);
            done_seen = 1'b1;
         end
      end
      prev_step_n = step_n;
      prev_done   = done;
   end

   task automatic wait_done();
      int n = 0;
      while (!done_seen && n < 20000) begin
         @(negedge clk); #1;
         n++;
      end
      if (!done_seen) chk("R8 command completes", 0, 1);
   endtask

   task automatic issue(input bit rc, input int t);
      @(negedge clk); #1;
      done_seen = 1'b0;
      have_fall = 1'b0;
      n_in = 0;
      n_out = 0;
      seek_req   = !rc;
      recal_req  = rc;
      seek_track = TW'(t);
      @(negedge clk); #1;
      seek_req  = 1'b0;
      recal_req = 1'b0;
   endtask

   task automatic run(input bit rc, input int t);
      issue(rc, t);
      wait_done();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      pos = 5;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset values
      chk("R1 step_n", int'(step_n), 1);
      chk("R1 dir_out", int'(dir_out), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 low_track", int'(low_track), 1);
      chk("R1 drive_present", int'(drive_present), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R5 first seek homes; R4 track zero found; R6 then steps out
      run(1'b0, 3);
      chk("R4 home steps", n_in, 5);
      chk("R6 out steps", n_out, 3);
      chk("R6 position", pos, 3);
      chk("R4 drive present", int'(drive_present), 1);
      chk("R9 low track", int'(low_track), 1);

      // R5 homed and nonzero target: no homing
      run(1'b0, 7);
      chk("R5 no home steps", n_in, 0);
      chk("R6 out steps", n_out, 4);
      chk("R6 position", pos, 7);

      // R11 requests while busy are dropped
      issue(1'b0, 10);
      repeat (15) @(negedge clk);
      #1;
      chk("R11 busy during seek", int'(busy), 1);
      seek_req = 1'b1; seek_track = TW'(2);
      @(negedge clk); #1;
      seek_req = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      recal_req = 1'b1;
      @(negedge clk); #1;
      recal_req = 1'b0;
      wait_done();
      repeat (40) @(negedge clk);
      #1;
      chk("R11 position kept", pos, 10);
      chk("R11 no inward steps", n_in, 0);
      chk("R11 idle afterwards", int'(busy), 0);

      // R7 slip to track zero: count resynchronised
      pos = 0;
      run(1'b0, 12);
      chk("R7 out steps after resync", n_out, 12);
      chk("R7 position", pos, 12);

      // R9/R6 sweep up and down across the threshold
      for (int t = 38; t <= 48; t++) begin
         run(1'b0, t);
         chk("R6 sweep up position", pos, t);
         chk("R9 sweep up low track", int'(low_track), (t < LOWLIM) ? 1 : 0);
      end
      for (int t = 47; t >= 36; t -= 1) begin
         run(1'b0, t);
         chk("R3 sweep down inward", n_in, 1);
         chk("R6 sweep down position", pos, t);
         chk("R9 sweep down low track", int'(low_track), (t < LOWLIM) ? 1 : 0);
      end

      // R5 target zero forces homing even when homed
      run(1'b0, 6);
      run(1'b0, 0);
      chk("R5 home on zero target", n_in, 6);
      chk("R5 position zero", pos, 0);
      chk("R4 present", int'(drive_present), 1);

      // R10 recalibrate from track 9, with a seek in the same cycle
      run(1'b0, 9);
      @(negedge clk); #1;
      done_seen = 1'b0; have_fall = 1'b0; n_in = 0; n_out = 0;
      seek_req = 1'b1; recal_req = 1'b1; seek_track = TW'(20);
      @(negedge clk); #1;
      seek_req = 1'b0; recal_req = 1'b0;
      wait_done();
      chk("R10 inward steps", n_in, 9);
      chk("R10 no outward steps", n_out, 0);
      chk("R10 position", pos, 0);
      chk("R10 low track", int'(low_track), 1);

      // R4 no drive: bounded homing reports absent
      connected = 1'b0;
      pos = 20;
      run(1'b1, 0);
      chk("R4 bounded home steps", n_in, HLIM);
      chk("R4 absent", int'(drive_present), 0);
      run(1'b0, 4);
      chk("R5 homed after absent", n_in, 0);
      chk("R6 out after absent", n_out, 4);

      // R4 head beyond the step budget
      connected = 1'b1;
      pos = 30;
      run(1'b1, 0);
      chk("R4 budget steps", n_in, HLIM);
      chk("R4 not found", int'(drive_present), 0);
      chk("R4 head left", pos, 30 - HLIM);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule